// File: doc/BRIEF.md
# Dual-Clock Audio Reclocking Buffer

This block takes stereo audio frames from a write domain and plays them out in a read domain. The write domain runs on a jittery clock recovered from the incoming stream. The read domain runs on a clean local master clock at 256 times the sample rate. The read side is the timing master. It divides its master clock with a synchronous counter to make a bit clock and a word clock, and it shifts each 24-bit sample out serially in I2S framing to a DAC.

While audio is playing, the block passes sample values through unchanged and in order. It never interpolates. The two clocks drift relative to each other, and the buffer depth absorbs that drift. When both channels stay quiet for a configurable number of consecutive frames, the read position is moved so that the buffer sits half full again. Any samples skipped or repeated by that move therefore fall inside the silent gap.

If the buffer does run dry, the last frame is held and a sticky flag is raised. If it fills up, new frames are discarded and a second sticky flag is raised. At start-up the output stays at zero until the buffer first reaches half full.

Top module: `audio_reclock_buffer`

## Requirements
- R1: `bclk` is the master clock divided by 4, high for 2 `mclk` cycles and low for 2. `lrclk` is the master clock divided by 256, low for 128 `mclk` cycles and high for 128. `lrclk` changes only in the cycle where `bclk` falls, so each frame holds 64 bit clocks.
- R2: In each half of a frame, `sdata` carries the 24-bit word MSB first. The MSB sits in the second bit-clock period after the `lrclk` edge (slot 1), and the LSB sits in slot 24. The left channel plays while `lrclk` is low. Slots 0 and 25 to 31 carry 0. `sdata` changes only when `bclk` falls.
- R3: Frames accepted on `wrValid` are played out bit-exact and in order of arrival, one frame per word-clock period.
- R4: After read reset, output frames are all zero until the buffer first holds at least DEPTH/2 frames at a frame boundary. While muted, an empty buffer does not raise `underrunFlag`.
- R5: When a frame boundary finds the buffer empty after playback has started, the previous frame is repeated and `underrunFlag` is set. The flag stays set until `rdFlagClear` is high for an `mclk` cycle in which no new underrun occurs.
- R6: A write that arrives while the buffer already holds DEPTH frames is discarded and sets `overrunFlag`. That flag stays set until `wrFlagClear` is high in a `wrClk` cycle with no new overrun. The buffer never holds more than DEPTH frames.
- R7: A frame counts as quiet when both channels, read as two's complement, have a magnitude strictly below `silenceLevel`. A magnitude equal to the level is not quiet. A level of 0 makes no frame quiet.
- R8: When the QUIET_FRAMES-th consecutive quiet frame is read, the read position jumps. The next frame played is the one DEPTH/2 entries before the newest write seen by the read side, so intervening frames are skipped, or earlier ones repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Recovered write-side clock |
| wrRstN | input | 1 | Active-low reset, write domain |
| wrValid | input | 1 | Frame present on wrLeft/wrRight this cycle |
| wrLeft | input | 24 | Left sample, two's complement |
| wrRight | input | 24 | Right sample, two's complement |
| wrFlagClear | input | 1 | Clears overrunFlag |
| overrunFlag | output | 1 | Sticky: a frame was discarded because the buffer was full |
| mclk | input | 1 | Local master clock, 256 x sample rate |
| rdRstN | input | 1 | Active-low reset, read domain |
| silenceLevel | input | 24 | Magnitude threshold for quiet frames |
| rdFlagClear | input | 1 | Clears underrunFlag |
| bclk | output | 1 | Serial bit clock |
| lrclk | output | 1 | Word clock, low for left channel |
| sdata | output | 1 | Serial audio data |
| underrunFlag | output | 1 | Sticky: a frame was repeated because the buffer was empty |

## Verification
The bench decodes the serial stream and compares every played frame against the frames it pushed. A wrong bit offset or swapped channel corrupts every word, and stray bits in the padding slots are counted separately. Bursts are aligned to the word clock, so the exact outcome of a full buffer is known: sixteen frames played and the last four lost. A design that wrapped instead of dropping would play the late frames over the early ones. The quiet-run tests include frames where only one channel is small and frames sitting exactly at the threshold. A re-centre on those would skip audible frames. A true quiet run must skip exactly two frames, and a design that failed to jump, or jumped by the wrong amount, would show an unbroken or differently broken sequence.

// File: rtl/reclk_pkg.sv
package reclk_pkg;
  localparam int SAMPLE_W       = 24;
  localparam int MCLK_PER_FRAME = 256;
  localparam int MCLK_PER_BCLK  = 4;
  localparam int DIV_W          = $clog2(MCLK_PER_FRAME);
  localparam int BCLK_BIT       = $clog2(MCLK_PER_BCLK) - 1;
  localparam int SLOT_W         = DIV_W - 1 - (BCLK_BIT + 1);

  typedef logic [SAMPLE_W-1:0] sample_t;

  typedef struct packed {
    sample_t left;
    sample_t right;
  } frame_t;

  // strobes from the read controller to the datapath
  typedef struct packed {
    logic              frameLoad;
    logic              pop;
    logic              recenter;
    logic              blank;
    logic              rightChan;
    logic [SLOT_W-1:0] slot;
  } rdStrobe_t;
endpackage

// File: rtl/reclk_datapath.sv
module reclk_datapath
  import reclk_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic      wrClk,
  input  logic      wrRstN,
  input  logic      wrValid,
  input  frame_t    wrFrame,
  input  logic      wrFlagClear,
  output logic      overrunFlag,
  input  logic      mclk,
  input  logic      rdRstN,
  input  rdStrobe_t strobe,
  output logic [PW-1:0] fillLevel,
  output frame_t    headFrame,
  output logic      sdata
);
  localparam int HALF = DEPTH / 2;

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  frame_t mem [DEPTH];

  logic [PW-1:0] wrBin, wrGray, rdBin, rdGray;
  logic [PW-1:0] rdGrayMeta, rdGraySync, wrGrayMeta, wrGraySync;

  // write domain
  logic [PW-1:0] rdBinAtWr;
  logic          full, accept;
  assign rdBinAtWr = fromGray(rdGraySync);
  assign full      = (wrBin - rdBinAtWr) == PW'(DEPTH);
  assign accept    = wrValid && !full;

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      rdGrayMeta  <= '0;
      rdGraySync  <= '0;
      wrBin       <= '0;
      wrGray      <= '0;
      overrunFlag <= 1'b0;
    end else begin
      rdGrayMeta <= rdGray;
      rdGraySync <= rdGrayMeta;
      if (accept) begin
        wrBin  <= wrBin + 1'b1;
        wrGray <= toGray(wrBin + 1'b1);
      end
      if (wrValid && full) overrunFlag <= 1'b1;
      else if (wrFlagClear) overrunFlag <= 1'b0;
    end
  end

  always_ff @(posedge wrClk) begin
    if (accept) mem[wrBin[AW-1:0]] <= wrFrame;
  end

  // read domain
  logic [PW-1:0] wrBinAtRd, rdNext;
  assign wrBinAtRd = fromGray(wrGraySync);
  assign fillLevel = wrBinAtRd - rdBin;
  assign headFrame = mem[rdBin[AW-1:0]];

  always_comb begin
    rdNext = rdBin;
    if (strobe.pop) rdNext = strobe.recenter ? wrBinAtRd - PW'(HALF) : rdBin + 1'b1;
  end

  frame_t  frameReg;
  sample_t chanWord;
  logic    bitNext;

  always_comb begin
    chanWord = strobe.rightChan ? frameReg.right : frameReg.left;
    bitNext  = 1'b0;
    for (int i = 1; i <= SAMPLE_W; i++)
      if (int'(strobe.slot) == i) bitNext = chanWord[SAMPLE_W-i];
  end

  always_ff @(posedge mclk or negedge rdRstN) begin
    if (!rdRstN) begin
      wrGrayMeta <= '0;
      wrGraySync <= '0;
      rdBin      <= '0;
      rdGray     <= '0;
      frameReg   <= '0;
      sdata      <= 1'b0;
    end else begin
      wrGrayMeta <= wrGray;
      wrGraySync <= wrGrayMeta;
      rdBin      <= rdNext;
      rdGray     <= toGray(rdNext);
      if (strobe.frameLoad) begin
        if (strobe.blank)    frameReg <= '0;
        else if (strobe.pop) frameReg <= headFrame;
      end
      sdata <= bitNext;
    end
  end
endmodule

// File: rtl/reclk_rdctrl.sv
module reclk_rdctrl
  import reclk_pkg::*;
#(
  parameter int DEPTH        = 64,
  parameter int QUIET_FRAMES = 2048,
  localparam int PW          = $clog2(DEPTH) + 1
) (
  input  logic          mclk,
  input  logic          rdRstN,
  input  logic [PW-1:0] fillLevel,
  input  frame_t        headFrame,
  input  sample_t       silenceLevel,
  input  logic          rdFlagClear,
  output rdStrobe_t     strobe,
  output logic          bclk,
  output logic          lrclk,
  output logic          underrunFlag,
  output logic          rdMuted
);
  localparam int HALF  = DEPTH / 2;
  localparam int RUN_W = $clog2(QUIET_FRAMES + 1);

  function automatic logic isQuiet(input sample_t s, input sample_t lvl);
    logic [SAMPLE_W:0] mag;
    mag = s[SAMPLE_W-1] ? ({(SAMPLE_W+1){1'b0}} - {s[SAMPLE_W-1], s}) : {1'b0, s};
    return mag < {1'b0, lvl};
  endfunction

  logic [DIV_W-1:0] divCnt;
  logic [RUN_W-1:0] quietRun;
  logic frameTick, empty, reachedHalf, headQuiet;

  assign frameTick   = divCnt == '1;
  assign empty       = fillLevel == '0;
  assign reachedHalf = fillLevel >= PW'(HALF);
  assign headQuiet   = isQuiet(headFrame.left, silenceLevel) &&
                       isQuiet(headFrame.right, silenceLevel);

  always_comb begin
    strobe.frameLoad = frameTick;
    strobe.blank     = rdMuted && !reachedHalf;
    strobe.pop       = frameTick && !strobe.blank && !empty;
    strobe.recenter  = strobe.pop && headQuiet && (quietRun == RUN_W'(QUIET_FRAMES - 1));
    strobe.rightChan = divCnt[DIV_W-1];
    strobe.slot      = divCnt[DIV_W-2:BCLK_BIT+1];
  end

  always_ff @(posedge mclk or negedge rdRstN) begin
    if (!rdRstN) begin
      divCnt       <= '0;
      bclk         <= 1'b0;
      lrclk        <= 1'b0;
      rdMuted      <= 1'b1;
      quietRun     <= '0;
      underrunFlag <= 1'b0;
    end else begin
      divCnt <= divCnt + 1'b1;
      bclk   <= divCnt[BCLK_BIT];
      lrclk  <= divCnt[DIV_W-1];
      if (frameTick && !strobe.blank) rdMuted <= 1'b0;
      if (strobe.pop) begin
        if (strobe.recenter || !headQuiet) quietRun <= '0;
        else                               quietRun <= quietRun + 1'b1;
      end
      if (frameTick && !strobe.blank && empty) underrunFlag <= 1'b1;
      else if (rdFlagClear)                    underrunFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/audio_reclock_buffer.sv
module audio_reclock_buffer
  import reclk_pkg::*;
#(
  parameter int DEPTH        = 64,
  parameter int QUIET_FRAMES = 2048
) (
  input  logic                wrClk,
  input  logic                wrRstN,
  input  logic                wrValid,
  input  logic [SAMPLE_W-1:0] wrLeft,
  input  logic [SAMPLE_W-1:0] wrRight,
  input  logic                wrFlagClear,
  output logic                overrunFlag,
  input  logic                mclk,
  input  logic                rdRstN,
  input  logic [SAMPLE_W-1:0] silenceLevel,
  input  logic                rdFlagClear,
  output logic                bclk,
  output logic                lrclk,
  output logic                sdata,
  output logic                underrunFlag
);
  localparam int PW = $clog2(DEPTH) + 1;

  frame_t        wrFrame, headFrame;
  rdStrobe_t     strobe;
  logic [PW-1:0] fillLevel;
  logic          rdMuted;

  assign wrFrame.left  = wrLeft;
  assign wrFrame.right = wrRight;

  reclk_datapath #(.DEPTH(DEPTH)) dataPath (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrValid(wrValid), .wrFrame(wrFrame),
    .wrFlagClear(wrFlagClear), .overrunFlag(overrunFlag),
    .mclk(mclk), .rdRstN(rdRstN), .strobe(strobe),
    .fillLevel(fillLevel), .headFrame(headFrame), .sdata(sdata)
  );

  reclk_rdctrl #(.DEPTH(DEPTH), .QUIET_FRAMES(QUIET_FRAMES)) rdCtrl (
    .mclk(mclk), .rdRstN(rdRstN), .fillLevel(fillLevel), .headFrame(headFrame),
    .silenceLevel(silenceLevel), .rdFlagClear(rdFlagClear), .strobe(strobe),
    .bclk(bclk), .lrclk(lrclk), .underrunFlag(underrunFlag), .rdMuted(rdMuted)
  );
endmodule

// File: rtl/audio_reclock_buffer_chk.sv
module audio_reclock_buffer_chk #(
  parameter int DEPTH = 64,
  localparam int PW   = $clog2(DEPTH) + 1
) (
  input logic          mclk,
  input logic          rdRstN,
  input logic          wrClk,
  input logic          wrRstN,
  input logic          bclk,
  input logic          lrclk,
  input logic          sdata,
  input logic          underrunFlag,
  input logic          rdFlagClear,
  input logic          overrunFlag,
  input logic          wrFlagClear,
  input logic          rdMuted,
  input logic [PW-1:0] fillLevel
);
  // R1
  bclk_high_width_chk: assert property (@(posedge mclk) disable iff (!rdRstN)
    $rose(bclk) |=> bclk ##1 !bclk);
  // R1
  bclk_low_width_chk: assert property (@(posedge mclk) disable iff (!rdRstN)
    $fell(bclk) |=> !bclk ##1 bclk);
  // R1
  word_edge_align_chk: assert property (@(posedge mclk) disable iff (!rdRstN)
    !$stable(lrclk) |-> $fell(bclk));
  // R2
  data_edge_align_chk: assert property (@(posedge mclk) disable iff (!rdRstN)
    !$stable(sdata) |-> $fell(bclk));
  // R4
  muted_silent_chk: assert property (@(posedge mclk) disable iff (!rdRstN)
    rdMuted |-> !sdata);
  // R5
  underrun_sticky_chk: assert property (@(posedge mclk) disable iff (!rdRstN)
    underrunFlag && !rdFlagClear |=> underrunFlag);
  // R6
  overrun_sticky_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    overrunFlag && !wrFlagClear |=> overrunFlag);
  // R6
  fill_bound_chk: assert property (@(posedge mclk) disable iff (!rdRstN)
    fillLevel <= PW'(DEPTH));
endmodule

bind audio_reclock_buffer audio_reclock_buffer_chk #(.DEPTH(DEPTH)) chk (
  .mclk(mclk), .rdRstN(rdRstN), .wrClk(wrClk), .wrRstN(wrRstN),
  .bclk(bclk), .lrclk(lrclk), .sdata(sdata), .underrunFlag(underrunFlag),
  .rdFlagClear(rdFlagClear), .overrunFlag(overrunFlag), .wrFlagClear(wrFlagClear),
  .rdMuted(rdMuted), .fillLevel(fillLevel)
);

// File: tb/audio_reclock_buffer_test.sv
module audio_reclock_buffer_test;
  localparam int DEPTH = 16;
  localparam int QUIET = 4;

  logic mclk = 0, wrClk = 0;
  logic wrRstN = 0, rdRstN = 0;
  logic wrValid = 0, wrFlagClear = 0, rdFlagClear = 0;
  logic [23:0] wrLeft = '0, wrRight = '0, silenceLevel = '0;
  logic bclk, lrclk, sdata, overrunFlag, underrunFlag;

  int checks = 0, errors = 0;

  always #2 mclk = ~mclk;
  always #3 wrClk = ~wrClk;

  audio_reclock_buffer #(.DEPTH(DEPTH), .QUIET_FRAMES(QUIET)) uut (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrValid(wrValid), .wrLeft(wrLeft),
    .wrRight(wrRight), .wrFlagClear(wrFlagClear), .overrunFlag(overrunFlag),
    .mclk(mclk), .rdRstN(rdRstN), .silenceLevel(silenceLevel),
    .rdFlagClear(rdFlagClear), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .underrunFlag(underrunFlag)
  );

  // serial decoder
  logic [23:0] recvL [512];
  logic [23:0] recvR [512];
  int recvCount = 0, badSlotBits = 0, slotCnt = 0;
  int mclkCount = 0, bclkRises = 0;
  logic prevBclk = 0, prevLr = 1;
  logic [23:0] shreg = '0, curL = '0;

  always @(negedge mclk) mclkCount++;
  always @(posedge bclk) bclkRises++;

  always @(negedge mclk) begin
    if (!rdRstN) begin
      prevBclk = 0; prevLr = 1; slotCnt = 0;
    end else begin
      if (bclk && !prevBclk) begin
        if (lrclk != prevLr) slotCnt = 0;
        else slotCnt++;
        prevLr = lrclk;
        if (slotCnt >= 1 && slotCnt <= 24) shreg = {shreg[22:0], sdata};
        else if (sdata) badSlotBits++;
        if (slotCnt == 24) begin
          if (!lrclk) curL = shreg;
          else if (recvCount < 512) begin
            recvL[recvCount] = curL;
            recvR[recvCount] = shreg;
            recvCount++;
          end
        end
      end
      prevBclk = bclk;
    end
  end

  logic [23:0] expL [32];
  logic [23:0] expR [32];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic frameStart();
    @(negedge lrclk);
    @(negedge mclk);
  endtask

  task automatic waitFrames(input int n);
    repeat (n) frameStart();
  endtask

  task automatic pushBurst(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wrClk);
      wrValid = 1; wrLeft = expL[i]; wrRight = expR[i];
    end
    @(negedge wrClk);
    wrValid = 0;
  endtask

  // find expL/R[0] from fromIdx, then expect n in order and a hold after
  task automatic checkSeq(input int fromIdx, input int n, input string req);
    int k = -1;
    for (int i = fromIdx; i < recvCount; i++)
      if (k < 0 && recvL[i] == expL[0] && recvR[i] == expR[0]) k = i;
    check(k >= 0, req, "first frame arrival", 48'h0, {expL[0], expR[0]});
    if (k < 0) return;
    for (int j = 0; j < n; j++)
      check(k + j < recvCount && recvL[k+j] == expL[j] && recvR[k+j] == expR[j],
            req, $sformatf("frame %0d", j), {recvL[k+j], recvR[k+j]}, {expL[j], expR[j]});
    // R5 hold of the last frame after the buffer empties
    check(k + n < recvCount && recvL[k+n] == expL[n-1] && recvR[k+n] == expR[n-1],
          "R5", "held frame", {recvL[k+n], recvR[k+n]}, {expL[n-1], expR[n-1]});
  endtask

  task automatic testReset();
    @(negedge mclk);
    check(sdata == 0, "R4", "sdata after reset", {47'h0, sdata}, 48'h0);
    check(underrunFlag == 0, "R5", "underrun after reset", {47'h0, underrunFlag}, 48'h0);
    check(overrunFlag == 0, "R6", "overrun after reset", {47'h0, overrunFlag}, 48'h0);
  endtask

  task automatic testClocks();
    int t0, t1, b0;
    @(posedge bclk); t0 = mclkCount;
    @(posedge bclk); t1 = mclkCount;
    check(t1 - t0 == 4, "R1", "bclk period", 48'(t1 - t0), 48'd4);
    @(negedge lrclk); t0 = mclkCount; b0 = bclkRises;
    @(posedge lrclk); t1 = mclkCount;
    check(t1 - t0 == 128, "R1", "lrclk low time", 48'(t1 - t0), 48'd128);
    @(negedge lrclk);
    check(mclkCount - t0 == 256, "R1", "lrclk period", 48'(mclkCount - t0), 48'd256);
    check(bclkRises - b0 == 64, "R1", "bclk per frame", 48'(bclkRises - b0), 48'd64);
  endtask

  task automatic testMuteAndUnderrun();
    int nz = 0;
    for (int i = 0; i < 8; i++) begin
      expL[i] = 24'h801000 + 24'(i * 3 + 1);
      expR[i] = 24'h3F0001 + 24'(i << 8);
    end
    pushBurst(7);
    waitFrames(5);
    for (int i = 0; i < recvCount; i++) if (recvL[i] != 0 || recvR[i] != 0) nz++;
    check(nz == 0 && recvCount > 2, "R4", "nonzero frames before half full", 48'(nz), 48'd0);
    check(underrunFlag == 0, "R4", "underrun while muted", {47'h0, underrunFlag}, 48'h0);
    frameStart();
    @(negedge wrClk);
    wrValid = 1; wrLeft = expL[7]; wrRight = expR[7];
    @(negedge wrClk);
    wrValid = 0;
    waitFrames(12);
    checkSeq(0, 8, "R3");
    check(underrunFlag == 1, "R5", "underrun flag set", {47'h0, underrunFlag}, 48'h1);
    frameStart();
    rdFlagClear = 1;
    @(negedge mclk);
    rdFlagClear = 0;
    repeat (10) @(negedge mclk);
    check(underrunFlag == 0, "R5", "underrun cleared", {47'h0, underrunFlag}, 48'h0);
    waitFrames(2);
    check(underrunFlag == 1, "R5", "underrun set again", {47'h0, underrunFlag}, 48'h1);
  endtask

  task automatic testOverrun();
    int start;
    for (int i = 0; i < 20; i++) begin
      expL[i] = 24'hA00000 + 24'(i * 5 + 1);
      expR[i] = 24'h5A0000 - 24'(i * 7 + 1);
    end
    frameStart();
    start = recvCount;
    pushBurst(20);
    repeat (3) @(negedge wrClk);
    check(overrunFlag == 1, "R6", "overrun flag set", {47'h0, overrunFlag}, 48'h1);
    wrFlagClear = 1;
    @(negedge wrClk);
    wrFlagClear = 0;
    @(negedge wrClk);
    check(overrunFlag == 0, "R6", "overrun cleared", {47'h0, overrunFlag}, 48'h0);
    waitFrames(20);
    checkSeq(start, 16, "R6");
  endtask

  task automatic setExp(input int i, input logic [23:0] l, input logic [23:0] r);
    expL[i] = l; expR[i] = r;
  endtask

  // R7: one-sided small frames and frames exactly at the level are not quiet
  task automatic testNotQuiet();
    int start;
    silenceLevel = 24'h000100;
    setExp(0, 24'h600001, 24'h9F0001);
    setExp(1, 24'hFFFFFB, 24'h000003);
    setExp(2, 24'h0000FF, 24'hFFFF01);
    setExp(3, 24'h000003, 24'h400000);
    setExp(4, 24'h000001, 24'h000000);
    setExp(5, 24'h000100, 24'h000001);
    setExp(6, 24'hFFFF01, 24'h000010);
    setExp(7, 24'h0000FF, 24'hFFFF01);
    setExp(8, 24'h000002, 24'hFFFF00);
    setExp(9, 24'h500000, 24'h000004);
    for (int i = 10; i < 15; i++) setExp(i, 24'h700000 + 24'(i), 24'h8A0000 + 24'(i));
    frameStart();
    start = recvCount;
    pushBurst(15);
    waitFrames(19);
    checkSeq(start, 15, "R7");
  endtask

  // R8: four quiet frames in a row re-centre the read position
  task automatic testRecenter();
    int start;
    setExp(0, 24'h610001, 24'h9E0001);
    setExp(1, 24'h620001, 24'h9D0001);
    setExp(2, 24'hFFFFFB, 24'h000003);
    setExp(3, 24'h0000FF, 24'hFFFF01);
    setExp(4, 24'h000001, 24'h000000);
    setExp(5, 24'hFFFF01, 24'h000010);
    for (int i = 6; i < 16; i++) setExp(i, 24'h300000 + 24'(i), 24'hC00000 + 24'(i));
    frameStart();
    start = recvCount;
    pushBurst(16);
    waitFrames(18);
    for (int i = 6; i < 14; i++) setExp(i, expL[i+2], expR[i+2]);
    checkSeq(start, 14, "R8");
  endtask

  initial begin
    repeat (5) @(negedge mclk);
    wrRstN = 1; rdRstN = 1;
    testReset();
    testClocks();
    testMuteAndUnderrun();
    testOverrun();
    testNotQuiet();
    testRecenter();
    check(badSlotBits == 0, "R2", "ones in padding slots", 48'(badSlotBits), 48'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule